// File: doc/BRIEF.md
# Graphic Display Host Interface Controller

This block is the host-facing control logic of a 64-column graphic display driver. The driver keeps a display memory of 8 pages, each 64 bytes wide. A host processor reaches the block over an 8-bit parallel bus. The bus carries three chip-select lines, a data/instruction select, a read/write direction line and an enable strobe. Through this bus the host can:

- switch the display on or off,
- set the column address, the page and the start line used for scrolling,
- write display bytes,
- read a status byte,
- read display bytes back.

The bus is handled as synchronous to the system clock. The enable strobe passes through two flip-flops and its falling edge is detected in the clock domain. Every accepted access is acted on two clock edges after the strobe is first sampled low.

Display reads pass through a one-byte output register. Each read hands back the byte that an earlier read fetched, then refills the register from the current page and column. After any address change the host must therefore issue one dummy read. A separate scan port lets the display refresh logic fetch bytes from the same single-port memory. Host accesses take priority, and a displaced scan fetch is served on the next free cycle. A display-reset input puts the block into a safe state while it is held low.

Top module: `glcd_host_ctrl`

## Requirements
- R1: A bus access takes effect only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1 while the strobe is high. A deselected access changes no column, page, start line, on/off state or memory byte.
- R2: `{sel_data, dir_rd}` selects the access type:
  - 00: instruction write.
  - 01: status read.
  - 10: display byte write.
  - 11: display byte read.
  
  Write data is taken as sampled while the strobe is high, and the write is acted on when the strobe falls. For a selected read, `bus_oe` is 1 from one clock after the strobe rises until one clock after it falls. For any other access `bus_oe` stays 0.
- R3: The instruction byte is decoded as follows:
  - `0011111d` sets the display on when d=1 and off when d=0.
  - `01cccccc` loads the 6-bit column.
  - `10111ppp` loads the 3-bit page.
  - `11ssssss` loads the 6-bit start line, which is shown on `start_line`.
  - Any other byte changes nothing.
- R4: The status byte has busy in bit 7, display-off in bit 5 (1 = off) and reset-active in bit 4. All other bits are 0. A status read returns the current status directly, with no dummy read.
- R5: The column steps up by one after every accepted display write or display read, and wraps from 63 to 0. The page changes only by instruction. Memory is addressed as {page, column}.
- R6: A display read returns the output register's previous contents, then reloads the register from memory at {page, column}. The first read after an address change therefore returns stale data. The register is 0 after system reset.
- R7: After every accepted access other than a status read, busy is 1 for BUSY_CYCLES clocks (default 2, range 1 to 3). Any non-status access that completes while busy is ignored.
- R8: While `panel_rst_n` is low:
  - the display is off,
  - the start line is 0,
  - status bit 4 reads 1,
  - only status reads are accepted.
- R9: A one-cycle `scan_req` with `scan_addr` = {page, column} gives `scan_valid`=1 and the stored byte on `scan_data` two clocks later. If a host memory access takes that cycle, the result comes one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| panel_rst_n | input | 1 | Display reset, active low |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| cs_c | input | 1 | Chip select C, active high |
| sel_data | input | 1 | 1 = display data, 0 = instruction/status |
| dir_rd | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Bus enable strobe |
| bus_in | input | 8 | Host write data |
| bus_out | output | 8 | Host read data |
| bus_oe | output | 1 | Read data drive enable |
| scan_req | input | 1 | Scan fetch request pulse |
| scan_addr | input | 9 | Scan fetch address {page, column} |
| scan_data | output | 8 | Scan fetch result |
| scan_valid | output | 1 | Scan result valid pulse |
| disp_on | output | 1 | Display on state |
| start_line | output | 6 | Scroll start line |

## Verification
Timing is counted from the clock edge that first samples the strobe low:
- The action itself (register load, memory write, column step) lands on the second edge after that.
- The output register refills on that same second edge.
- Busy holds for two further edges.
- Read data appears on `bus_out` one edge after the strobe is sampled high.

The bench drives every input on falling clock edges and samples on falling edges. It leaves four idle cycles between accesses, so each result has settled and busy has cleared before the next access. Only the busy tests place a second access one cycle behind the first, so that it lands inside the busy window. The scan checks look for the result on exactly the second edge after the request, or the third edge when a host write takes the memory first.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    localparam int DW    = 8;
    localparam int COLW  = 6;
    localparam int PAGEW = 3;
    localparam int AW    = PAGEW + COLW;
    localparam int DEPTH = 1 << AW;

    typedef enum logic [1:0] {
        ACC_INSTR  = 2'b00,
        ACC_STATUS = 2'b01,
        ACC_WRITE  = 2'b10,
        ACC_READ   = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ONOFF,
        OP_COL,
        OP_PAGE,
        OP_START
    } op_e;

    typedef struct packed {
        logic          sel;
        logic          rs;
        logic          rw;
        logic [DW-1:0] data;
    } bus_smp_t;

    typedef struct packed {
        op_e             op;
        logic [COLW-1:0] arg;
    } instr_t;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_req_t;

    function automatic instr_t decode_instr(input logic [DW-1:0] b);
        instr_t r;
        r.op  = OP_NONE;
        r.arg = b[COLW-1:0];
        if (b[7:1] == 7'b0011111)     r.op = OP_ONOFF;
        else if (b[7:6] == 2'b01)     r.op = OP_COL;
        else if (b[7:3] == 5'b10111)  r.op = OP_PAGE;
        else if (b[7:6] == 2'b11)     r.op = OP_START;
        return r;
    endfunction

    function automatic acc_e kind_of(input bus_smp_t s);
        return acc_e'({s.rs, s.rw});
    endfunction

    function automatic logic [DW-1:0] status_byte(input logic busy,
                                                  input logic on,
                                                  input logic in_rst);
        return {busy, 1'b0, ~on, in_rst, 4'b0000};
    endfunction

endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync
    import glcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic          cs_c,
    input  logic          sel_data,
    input  logic          dir_rd,
    input  logic [DW-1:0] bus_in,
    output logic          en_live,
    output logic          fall,
    output bus_smp_t      smp_live,
    output bus_smp_t      smp_held
);

    logic     en_q1, en_q2;
    bus_smp_t now;

    always_comb begin
        now.sel  = ~cs_a_n & ~cs_b_n & cs_c;
        now.rs   = sel_data;
        now.rw   = dir_rd;
        now.data = bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q1    <= 1'b0;
            en_q2    <= 1'b0;
            smp_live <= '0;
            smp_held <= '0;
        end else begin
            en_q1    <= strobe;
            en_q2    <= en_q1;
            smp_live <= now;
            if (en_q1) smp_held <= smp_live;
        end
    end

    assign en_live = en_q1;
    assign fall    = en_q2 & ~en_q1;

endmodule

// File: rtl/glcd_cmd_regs.sv
module glcd_cmd_regs
    import glcd_pkg::*;
#(
    parameter int BUSY_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             panel_rst_n,
    input  logic             fall,
    input  bus_smp_t         held,
    output logic [COLW-1:0]  col,
    output logic [PAGEW-1:0] page,
    output logic [COLW-1:0]  start_line,
    output logic             disp_on,
    output logic             busy,
    output logic             rst_hold,
    output mem_req_t         mreq
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] busy_cnt;
    acc_e          kind;
    instr_t        ins;
    logic          go, do_instr, do_wr, do_rd;

    assign kind     = kind_of(held);
    assign ins      = decode_instr(held.data);
    assign busy     = (busy_cnt != '0);
    assign go       = fall & held.sel & ~busy & ~rst_hold;
    assign do_instr = go & (kind == ACC_INSTR);
    assign do_wr    = go & (kind == ACC_WRITE);
    assign do_rd    = go & (kind == ACC_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            col        <= '0;
            page       <= '0;
            start_line <= '0;
            disp_on    <= 1'b0;
            busy_cnt   <= '0;
            rst_hold   <= 1'b0;
        end else begin
            rst_hold <= ~panel_rst_n;
            if (do_wr | do_rd) col <= col + COLW'(1);
            if (do_instr) begin
                case (ins.op)
                    OP_ONOFF: disp_on    <= ins.arg[0];
                    OP_COL:   col        <= ins.arg;
                    OP_PAGE:  page       <= ins.arg[PAGEW-1:0];
                    OP_START: start_line <= ins.arg;
                    default:  ;
                endcase
            end
            if (rst_hold) begin
                disp_on    <= 1'b0;
                start_line <= '0;
            end
            if (do_instr | do_wr | do_rd)
                busy_cnt <= BW'(BUSY_CYCLES);
            else if (busy)
                busy_cnt <= busy_cnt - BW'(1);
        end
    end

    always_comb begin
        mreq.we    = do_wr;
        mreq.re    = do_rd;
        mreq.addr  = {page, col};
        mreq.wdata = held.data;
    end

endmodule

// File: rtl/glcd_frame_mem.sv
module glcd_frame_mem
    import glcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  mem_req_t      hreq,
    input  logic          scan_req,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] out_reg,
    output logic [DW-1:0] scan_data,
    output logic          scan_valid
);

    logic [DW-1:0] mem [DEPTH];
    logic          pend;
    logic [AW-1:0] paddr;
    logic          host_busy, serve;
    logic [AW-1:0] addr;

    assign host_busy = hreq.we | hreq.re;
    assign serve     = pend & ~host_busy;
    assign addr      = host_busy ? hreq.addr : paddr;

    always_ff @(posedge clk) begin
        if (hreq.we) mem[addr] <= hreq.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_reg    <= '0;
            scan_data  <= '0;
            scan_valid <= 1'b0;
            pend       <= 1'b0;
            paddr      <= '0;
        end else begin
            scan_valid <= serve;
            if (hreq.re) out_reg   <= mem[addr];
            if (serve)   scan_data <= mem[addr];
            if (scan_req) begin
                pend  <= 1'b1;
                paddr <= scan_addr;
            end else if (serve) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/glcd_host_ctrl.sv
module glcd_host_ctrl
    import glcd_pkg::*;
#(
    parameter int BUSY_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             panel_rst_n,
    input  logic             cs_a_n,
    input  logic             cs_b_n,
    input  logic             cs_c,
    input  logic             sel_data,
    input  logic             dir_rd,
    input  logic             strobe,
    input  logic [DW-1:0]    bus_in,
    output logic [DW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic             scan_req,
    input  logic [AW-1:0]    scan_addr,
    output logic [DW-1:0]    scan_data,
    output logic             scan_valid,
    output logic             disp_on,
    output logic [COLW-1:0]  start_line
);

    logic             en_live, fall, busy, rst_hold;
    bus_smp_t         smp_live, smp_held;
    logic [COLW-1:0]  col;
    logic [PAGEW-1:0] page;
    mem_req_t         mreq;
    logic [DW-1:0]    out_reg;

    glcd_bus_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .cs_a_n   (cs_a_n),
        .cs_b_n   (cs_b_n),
        .cs_c     (cs_c),
        .sel_data (sel_data),
        .dir_rd   (dir_rd),
        .bus_in   (bus_in),
        .en_live  (en_live),
        .fall     (fall),
        .smp_live (smp_live),
        .smp_held (smp_held)
    );

    glcd_cmd_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .panel_rst_n (panel_rst_n),
        .fall        (fall),
        .held        (smp_held),
        .col         (col),
        .page        (page),
        .start_line  (start_line),
        .disp_on     (disp_on),
        .busy        (busy),
        .rst_hold    (rst_hold),
        .mreq        (mreq)
    );

    glcd_frame_mem u_mem (
        .clk        (clk),
        .rst        (rst),
        .hreq       (mreq),
        .scan_req   (scan_req),
        .scan_addr  (scan_addr),
        .out_reg    (out_reg),
        .scan_data  (scan_data),
        .scan_valid (scan_valid)
    );

    assign bus_oe  = en_live & smp_live.sel & smp_live.rw;
    assign bus_out = smp_live.rs ? out_reg : status_byte(busy, disp_on, rst_hold);

endmodule

// File: rtl/glcd_host_ctrl_chk.sv
module glcd_host_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe,
    input logic       dir_rd,
    input logic       bus_oe,
    input logic [7:0] bus_out,
    input logic       live_rs,
    input logic       fall,
    input logic       held_sel,
    input logic       host_we,
    input logic       host_re,
    input logic [5:0] col,
    input logic [2:0] page,
    input logic       busy,
    input logic       disp_on,
    input logic [5:0] start_line,
    input logic       rst_hold,
    input logic       scan_valid
);

    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        (fall && !held_sel && !rst_hold) |=>
            ($stable(col) && $stable(page) && $stable(disp_on) && $stable(start_line)));

    assert_oe_read_R2: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ($past(strobe) && $past(dir_rd)));

    assert_status_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !live_rs) |-> (bus_out[6] == 1'b0 && bus_out[3:0] == 4'b0000));

    assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
        (host_we || host_re) |=> (col == $past(col) + 6'd1 && $stable(page)));

    assert_busy_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (host_we || host_re) |=> busy);

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rst_hold |=> (!disp_on && start_line == 6'd0));

    assert_scan_yield_R9: assert property (@(posedge clk) disable iff (rst)
        scan_valid |-> !$past(host_we || host_re));

endmodule

bind glcd_host_ctrl glcd_host_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .dir_rd     (dir_rd),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .live_rs    (smp_live.rs),
    .fall       (fall),
    .held_sel   (smp_held.sel),
    .host_we    (mreq.we),
    .host_re    (mreq.re),
    .col        (col),
    .page       (page),
    .busy       (busy),
    .disp_on    (disp_on),
    .start_line (start_line),
    .rst_hold   (rst_hold),
    .scan_valid (scan_valid)
);

// File: tb/tb_glcd_host_ctrl.sv
`timescale 1ns/1ps
module tb_glcd_host_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       panel_rst_n = 1'b1;
    logic       cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
    logic       sel_data = 1'b0, dir_rd = 1'b0, strobe = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       scan_req = 1'b0;
    logic [8:0] scan_addr = 9'h000;
    logic [7:0] scan_data;
    logic       scan_valid;
    logic       disp_on;
    logic [5:0] start_line;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    glcd_host_ctrl dut (
        .clk(clk), .rst(rst), .panel_rst_n(panel_rst_n),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c),
        .sel_data(sel_data), .dir_rd(dir_rd), .strobe(strobe),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .scan_req(scan_req), .scan_addr(scan_addr),
        .scan_data(scan_data), .scan_valid(scan_valid),
        .disp_on(disp_on), .start_line(start_line)
    );

    typedef struct packed {
        logic       r_s;
        logic       r_w;
        logic [7:0] d;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 8'h3F, 1'b0, 8'h00},  // R3 display on
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R4 status: on, ready
        '{1'b0, 1'b0, 8'hBA, 1'b0, 8'h00},  // R3 page 2
        '{1'b0, 1'b0, 8'h45, 1'b0, 8'h00},  // R3 column 5
        '{1'b1, 1'b0, 8'hA5, 1'b0, 8'h00},  // R2 write
        '{1'b1, 1'b0, 8'h3C, 1'b0, 8'h00},  // R5 write at column 6
        '{1'b0, 1'b0, 8'h45, 1'b0, 8'h00},  // column 5 again
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h00},  // R6 dummy read returns reset value
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'hA5},  // R6 first real byte
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h3C},  // R5 column advanced on read
        '{1'b0, 1'b0, 8'hBB, 1'b0, 8'h00},  // page 3
        '{1'b0, 1'b0, 8'h45, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'h77, 1'b0, 8'h00},  // page 3 column 5
        '{1'b0, 1'b0, 8'hBA, 1'b0, 8'h00},  // back to page 2
        '{1'b0, 1'b0, 8'h45, 1'b0, 8'h00},
        '{1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // dummy, stale contents
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'hA5},  // R5 pages kept apart
        '{1'b0, 1'b0, 8'h3E, 1'b0, 8'h00},  // R3 display off
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h20},  // R4 off bit
        '{1'b0, 1'b0, 8'h3F, 1'b0, 8'h00},  // on again
        '{1'b0, 1'b0, 8'h2F, 1'b0, 8'h00},  // R3 undefined byte, no effect
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00}   // R3 still on
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic acc(input logic ok, input logic r_s, input logic r_w,
                       input logic [7:0] d, input int hi, input int gap,
                       output logic [7:0] rd, output logic oe);
        cs_a_n   = ~ok;
        cs_b_n   = 1'b0;
        cs_c     = ok;
        sel_data = r_s;
        dir_rd   = r_w;
        bus_in   = d;
        strobe   = 1'b1;
        repeat (hi) @(negedge clk);
        rd = bus_out;
        oe = bus_oe;
        strobe = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic       oe;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R8 reset disp_on", {7'd0, disp_on}, 8'h00);
        chk("R8 reset start_line", {2'd0, start_line}, 8'h00);
        chk("R2 idle bus_oe", {7'd0, bus_oe}, 8'h00);
        chk("R9 idle scan_valid", {7'd0, scan_valid}, 8'h00);
        acc(1'b1, 1'b0, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R4 reset status", rd, 8'h20);
        chk("R2 status oe", {7'd0, oe}, 8'h01);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            acc(1'b1, VT[i].r_s, VT[i].r_w, VT[i].d, 3, 4, rd, oe);
            if (VT[i].chk) chk($sformatf("R2 vector %0d", i), rd, VT[i].exp);
        end

        // R2: no drive on write
        acc(1'b1, 1'b1, 1'b0, 8'hEE, 3, 4, rd, oe);
        chk("R2 write no oe", {7'd0, oe}, 8'h00);

        // R3: start line
        acc(1'b1, 1'b0, 1'b0, 8'hD1, 3, 4, rd, oe);
        chk("R3 start line", {2'd0, start_line}, 8'h11);

        // R5: column wrap 63 -> 0
        acc(1'b1, 1'b0, 1'b0, 8'hBA, 3, 4, rd, oe);
        acc(1'b1, 1'b0, 1'b0, 8'h7F, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b0, 8'h11, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b0, 8'h22, 3, 4, rd, oe);
        acc(1'b1, 1'b0, 1'b0, 8'h7F, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b1, 8'h00, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R5 column 63", rd, 8'h11);
        acc(1'b1, 1'b1, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R5 wrapped to 0", rd, 8'h22);

        // R1: deselected accesses
        acc(1'b0, 1'b0, 1'b0, 8'h3E, 3, 4, rd, oe);
        chk("R1 deselected off ignored", {7'd0, disp_on}, 8'h01);
        acc(1'b0, 1'b0, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R1 deselected no oe", {7'd0, oe}, 8'h00);
        acc(1'b1, 1'b0, 1'b0, 8'h4A, 3, 4, rd, oe);
        acc(1'b0, 1'b1, 1'b0, 8'h99, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b0, 8'h55, 3, 4, rd, oe);
        acc(1'b1, 1'b0, 1'b0, 8'h4A, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b1, 8'h00, 3, 4, rd, oe);
        acc(1'b1, 1'b1, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R1 deselected write skipped", rd, 8'h55);

        // R7: busy visible right after an instruction
        acc(1'b1, 1'b0, 1'b0, 8'h3E, 3, 1, rd, oe);
        acc(1'b1, 1'b0, 1'b1, 8'h00, 1, 6, rd, oe);
        chk("R7 busy in status", rd, 8'hA0);
        acc(1'b1, 1'b0, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R7 busy cleared", rd, 8'h20);
        // R7: instruction landing in the busy window is dropped
        acc(1'b1, 1'b0, 1'b0, 8'h3F, 3, 1, rd, oe);
        acc(1'b1, 1'b0, 1'b0, 8'h3E, 1, 6, rd, oe);
        chk("R7 busy rejects", {7'd0, disp_on}, 8'h01);

        // R9: scan fetch of page 2 column 5
        scan_addr = 9'h085;
        scan_req  = 1'b1;
        @(negedge clk);
        scan_req = 1'b0;
        chk("R9 not yet valid", {7'd0, scan_valid}, 8'h00);
        @(negedge clk);
        chk("R9 scan valid", {7'd0, scan_valid}, 8'h01);
        chk("R9 scan data", scan_data, 8'hA5);
        repeat (3) @(negedge clk);

        // R9: scan displaced by a host write to page 2 column 20
        acc(1'b1, 1'b0, 1'b0, 8'h54, 3, 4, rd, oe);
        cs_a_n = 1'b0; cs_b_n = 1'b0; cs_c = 1'b1;
        sel_data = 1'b1; dir_rd = 1'b0; bus_in = 8'h6B; strobe = 1'b1;
        repeat (3) @(negedge clk);
        strobe    = 1'b0;
        scan_addr = 9'h094;
        scan_req  = 1'b1;
        @(negedge clk);
        scan_req = 1'b0;
        @(negedge clk);
        chk("R9 displaced", {7'd0, scan_valid}, 8'h00);
        @(negedge clk);
        chk("R9 retried valid", {7'd0, scan_valid}, 8'h01);
        chk("R9 retried data", scan_data, 8'h6B);
        repeat (4) @(negedge clk);

        // R8: display reset
        panel_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 off in reset", {7'd0, disp_on}, 8'h00);
        chk("R8 start cleared", {2'd0, start_line}, 8'h00);
        acc(1'b1, 1'b0, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R8 status in reset", rd, 8'h30);
        acc(1'b1, 1'b0, 1'b0, 8'h3F, 3, 4, rd, oe);
        chk("R8 instruction refused", {7'd0, disp_on}, 8'h00);
        acc(1'b1, 1'b0, 1'b0, 8'hC5, 3, 4, rd, oe);
        chk("R8 start refused", {2'd0, start_line}, 8'h00);
        panel_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        acc(1'b1, 1'b0, 1'b1, 8'h00, 3, 4, rd, oe);
        chk("R8 status after release", rd, 8'h20);
        acc(1'b1, 1'b0, 1'b0, 8'h3F, 3, 4, rd, oe);
        chk("R8 instructions resume", {7'd0, disp_on}, 8'h01);

        finish_run();
    end

endmodule